// File: doc/BRIEF.md
# Serial Controller Interrupt Flag Unit

This block keeps the status flags and interrupt enables of a serial controller that works either as an I2C-bus controller or as a clocked synchronous serial port. The transfer engine sends single-cycle event pulses into the block:

- the transmit buffer moved into the shift register
- the last byte finished
- a byte arrived
- a stop condition was seen
- a NACK came back
- arbitration was lost or an overrun happened

Each pulse sets a sticky flag. The CPU clears a flag in one of two ways. Some flags clear as a side effect of a data-register access. The others clear when software writes zero to them.

Each flag is ANDed with its enable bit and qualified by the current mode. The result drives one interrupt line per source. A single combined request is also provided for the shared vector. Because the vector is shared, software reads the flag vector to find the cause.

The stop and NACK conditions only exist on the I2C bus. In clocked synchronous mode, the stop request stays low. The NACK line then reports only arbitration-lost/overrun.

Top module: `sif_irq_unit`

## Requirements
- R1: On a synchronous active-low reset, `flags_o` becomes 6'b000001 (only the transmit-empty flag is set), `enables_o` becomes 0, and all interrupt outputs are low.
- R2: The flag bit positions are: transmit-empty bit 0, transmit-done bit 1, receive-full bit 2, stop bit 3, nack bit 4, arbitration-lost/overrun bit 5. Each event pulse (`ev_xfer`, `ev_txend`, `ev_rxbyte`, `ev_stop`, `ev_nack`, `ev_arblost`) sets its flag on the next clock edge. The flag then holds until it is cleared.
- R3: A `txdata_wr` pulse clears flag bits 0 and 1 on the next edge.
- R4: An `rxdata_rd` pulse clears flag bit 2 on the next edge.
- R5: A `stat_wr` pulse clears each of flag bits 3, 4 and 5 whose `stat_wdata` bit is 0. A 1 in those bits leaves the flag unchanged. `stat_wdata` bits 0 to 2 have no effect.
- R6: When a set event and a clear of the same flag fall in the same cycle, the flag ends up 1.
- R7: An `en_wr` pulse loads `en_wdata` into `enables_o` on the next edge. The enable bits are: transmit-empty bit 0, transmit-done bit 1, receive-full bit 2, stop bit 3, nack bit 4. Without `en_wr`, the enables hold.
- R8: The following outputs are combinational from the registered state, in both modes:
  - `irq_txe` = enable 0 AND flag 0
  - `irq_tend` = enable 1 AND flag 1
  - `irq_rxf` = enable 2 AND flag 2
- R9: `irq_stop` = `mode_i2c` AND enable 3 AND flag 3. It is always low in synchronous mode (`mode_i2c` = 0).
- R10: `irq_nak` depends on the mode:
  - In I2C mode it is enable 4 AND (flag 4 OR flag 5).
  - In synchronous mode it is enable 4 AND flag 5, and the nack flag is ignored.
- R11: `irq_any` is the OR of the five individual interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i2c | input | 1 | 1 = I2C-bus mode, 0 = clocked synchronous mode |
| ev_xfer | input | 1 | Transmit buffer moved into the shift register |
| ev_txend | input | 1 | Transmission finished |
| ev_rxbyte | input | 1 | Byte received into the receive buffer |
| ev_stop | input | 1 | Stop condition detected |
| ev_nack | input | 1 | NACK received |
| ev_arblost | input | 1 | Arbitration lost or overrun |
| txdata_wr | input | 1 | CPU write strobe of the transmit data register |
| rxdata_rd | input | 1 | CPU read strobe of the receive data register |
| stat_wr | input | 1 | CPU write strobe of the flag register |
| stat_wdata | input | 6 | Write data for the flag register |
| en_wr | input | 1 | CPU write strobe of the enable register |
| en_wdata | input | 5 | Write data for the enable register |
| flags_o | output | 6 | Current flags |
| enables_o | output | 5 | Current enables |
| irq_txe | output | 1 | Transmit-empty request |
| irq_tend | output | 1 | Transmit-done request |
| irq_rxf | output | 1 | Receive-full request |
| irq_stop | output | 1 | Stop request |
| irq_nak | output | 1 | NACK / arbitration-lost request |
| irq_any | output | 1 | Combined request |

## Verification
The main function is driven with random event and access patterns, with strobe densities high enough that same-cycle set/clear collisions happen often. This separates a set-wins priority from a clear-wins one, and separates side-effect clears from write-zero clears.

Status writes carry random data. This checks that ones preserve flags and that writes to the low bits do nothing.

The mode is toggled between blocks of cycles while the stop, nack and arbitration flags are set. A mode-blind stop gate, or a NACK gate that ignores the mode, therefore shows up as a mismatch against the model.

A mid-run reset checks that the transmit-empty flag returns to 1 while all other state returns to 0.

// File: rtl/sif_irq_pkg.sv
// Shared widths and bit positions of the serial interrupt flag unit.
package sif_irq_pkg;
    localparam int FLAG_W = 6;
    localparam int EN_W   = 5;
    localparam int IRQ_W  = 5;

    // flag bit positions
    localparam int F_TXE  = 0;
    localparam int F_TEND = 1;
    localparam int F_RXF  = 2;
    localparam int F_STOP = 3;
    localparam int F_NACK = 4;
    localparam int F_ARB  = 5;

    // first flag cleared by software write-zero
    localparam int F_SW_LO = F_STOP;

    // enable / request bit positions
    localparam int E_TXE  = 0;
    localparam int E_TEND = 1;
    localparam int E_RXF  = 2;
    localparam int E_STOP = 3;
    localparam int E_NAK  = 4;

    // reset value of the flags: transmit buffer starts empty
    localparam logic [FLAG_W-1:0] FLAG_RST = FLAG_W'(1) << F_TXE;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [EN_W-1:0]   en_vec_t;
    typedef logic [IRQ_W-1:0]  irq_vec_t;
endpackage

// File: rtl/sif_flag_bank.sv
// Bank of sticky flags with per-bit set and clear requests.
// Assumes: set and clear arrive as one-cycle pulses; set has priority.
module sif_flag_bank #(
    parameter int                N       = 6,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flag: reset value, then set beats clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= RST_VAL[i];
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end

        // R6: a set in the same cycle as a clear still leaves the flag at 1
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);

        // R3, R4, R5: a lone clear drops the flag
        a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);

        // R2: with no request the flag holds
        a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
    end
endmodule

// File: rtl/sif_enable_reg.sv
// Interrupt enable register, loaded by a CPU write strobe.
// Assumes: write data is valid in the cycle of the strobe.
module sif_enable_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    // Hold enables; clear on reset, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= wdata_i;
    end

    // R7: the register changes only on a write
    a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o));

    // R7: a write loads its data
    a_r7_en_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/sif_irq_combine.sv
// Combines flags with enables and the mode to form the request lines.
// Assumes: the stop and nack conditions exist only in I2C mode; in
// synchronous mode the nack line reports arbitration-lost/overrun only.
module sif_irq_combine
    import sif_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_i2c,
    input  flag_vec_t flags_i,
    input  en_vec_t   en_i,
    output irq_vec_t  irq_o,
    output logic      any_o
);
    logic nak_cause;

    // Select the nack cause: both flags in I2C mode, overrun only otherwise.
    always_comb begin
        nak_cause = flags_i[F_ARB] | (mode_i2c & flags_i[F_NACK]);
    end

    // Gate each source with its enable and, where needed, the mode.
    always_comb begin
        irq_o         = '0;
        irq_o[E_TXE]  = en_i[E_TXE]  & flags_i[F_TXE];
        irq_o[E_TEND] = en_i[E_TEND] & flags_i[F_TEND];
        irq_o[E_RXF]  = en_i[E_RXF]  & flags_i[F_RXF];
        irq_o[E_STOP] = en_i[E_STOP] & flags_i[F_STOP] & mode_i2c;
        irq_o[E_NAK]  = en_i[E_NAK]  & nak_cause;
        any_o         = |irq_o;
    end

    // R9: no stop request in synchronous mode
    a_r9_stop_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i2c |-> !irq_o[E_STOP]);

    // R10: in synchronous mode the nack flag alone raises nothing
    a_r10_nack_masked_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i2c && !flags_i[F_ARB]) |-> !irq_o[E_NAK]);

    // R8: a disabled source never requests
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i[E_RXF] |-> !irq_o[E_RXF]);
endmodule

// File: rtl/sif_irq_unit.sv
// Interrupt flag unit of a dual-mode serial controller (I2C / clocked sync).
// Maps engine events and CPU accesses onto flag set/clear requests, keeps
// the enables and drives per-source and combined interrupt requests.
// Assumes: all strobes are single-cycle and synchronous to clk.
module sif_irq_unit
    import sif_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i2c,
    input  logic              ev_xfer,
    input  logic              ev_txend,
    input  logic              ev_rxbyte,
    input  logic              ev_stop,
    input  logic              ev_nack,
    input  logic              ev_arblost,
    input  logic              txdata_wr,
    input  logic              rxdata_rd,
    input  logic              stat_wr,
    input  logic [FLAG_W-1:0] stat_wdata,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    output logic [FLAG_W-1:0] flags_o,
    output logic [EN_W-1:0]   enables_o,
    output logic              irq_txe,
    output logic              irq_tend,
    output logic              irq_rxf,
    output logic              irq_stop,
    output logic              irq_nak,
    output logic              irq_any
);
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    irq_vec_t  irq_vec;

    // Route the engine events to their flag positions.
    always_comb begin
        set_vec         = '0;
        set_vec[F_TXE]  = ev_xfer;
        set_vec[F_TEND] = ev_txend;
        set_vec[F_RXF]  = ev_rxbyte;
        set_vec[F_STOP] = ev_stop;
        set_vec[F_NACK] = ev_nack;
        set_vec[F_ARB]  = ev_arblost;
    end

    // Derive clears from data-register side effects and write-zero accesses.
    always_comb begin
        clr_vec         = '0;
        clr_vec[F_TXE]  = txdata_wr;
        clr_vec[F_TEND] = txdata_wr;
        clr_vec[F_RXF]  = rxdata_rd;
        for (int b = F_SW_LO; b < FLAG_W; b++)
            clr_vec[b] = stat_wr & ~stat_wdata[b];
    end

    sif_flag_bank #(.N(FLAG_W), .RST_VAL(FLAG_RST)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags_o)
    );

    sif_enable_reg #(.W(EN_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (en_wdata),
        .q_o     (enables_o)
    );

    sif_irq_combine u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i2c (mode_i2c),
        .flags_i  (flags_o),
        .en_i     (enables_o),
        .irq_o    (irq_vec),
        .any_o    (irq_any)
    );

    // Break the request vector out to named outputs.
    always_comb begin
        irq_txe  = irq_vec[E_TXE];
        irq_tend = irq_vec[E_TEND];
        irq_rxf  = irq_vec[E_RXF];
        irq_stop = irq_vec[E_STOP];
        irq_nak  = irq_vec[E_NAK];
    end

    // R3: a transmit write without a buffer transfer empties the flag
    a_r3_txwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (txdata_wr && !ev_xfer) |=> !flags_o[F_TXE]);

    // R5: a status write with ones keeps the stop flag
    a_r5_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata[F_STOP] && flags_o[F_STOP]) |=> flags_o[F_STOP]);

    // R4: a receive read without a new byte empties the receive flag
    a_r4_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdata_rd && !ev_rxbyte) |=> !flags_o[F_RXF]);
endmodule

// File: tb/sim_sif_irq_unit.sv
module sim_sif_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 0, rst_n = 0, mode_i2c = 1;
    logic ev_xfer = 0, ev_txend = 0, ev_rxbyte = 0, ev_stop = 0, ev_nack = 0, ev_arblost = 0;
    logic txdata_wr = 0, rxdata_rd = 0, stat_wr = 0, en_wr = 0;
    logic [5:0] stat_wdata = 0;
    logic [4:0] en_wdata = 0;
    logic [5:0] flags_o;
    logic [4:0] enables_o;
    logic irq_txe, irq_tend, irq_rxf, irq_stop, irq_nak, irq_any;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    // reference model state
    bit m_f[6];
    bit m_e[5];
    string flag_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sif_irq_unit u0 (.*);

    // Behavioural model: applies this cycle's accesses then events.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_f[i]) m_f[i] = (i == 0);
            foreach (m_e[i]) m_e[i] = 0;
        end else begin
            if (txdata_wr) begin m_f[0] = 0; m_f[1] = 0; end
            if (rxdata_rd) m_f[2] = 0;
            if (stat_wr) for (int b = 3; b < 6; b++) if (!stat_wdata[b]) m_f[b] = 0;
            if (ev_xfer)    m_f[0] = 1;
            if (ev_txend)   m_f[1] = 1;
            if (ev_rxbyte)  m_f[2] = 1;
            if (ev_stop)    m_f[3] = 1;
            if (ev_nack)    m_f[4] = 1;
            if (ev_arblost) m_f[5] = 1;
            if (en_wr) foreach (m_e[i]) m_e[i] = en_wdata[i];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        int ef = 0, ee = 0;
        bit x_txe, x_tend, x_rxf, x_stop, x_nak;
        foreach (m_f[i]) if (m_f[i]) ef |= (1 << i);
        foreach (m_e[i]) if (m_e[i]) ee |= (1 << i);
        x_txe  = m_e[0] && m_f[0];
        x_tend = m_e[1] && m_f[1];
        x_rxf  = m_e[2] && m_f[2];
        x_stop = mode_i2c && m_e[3] && m_f[3];
        x_nak  = m_e[4] && (m_f[5] || (mode_i2c && m_f[4]));
        chk(flag_tag, flags_o, ef);
        chk("R7 enables", enables_o, ee);
        chk("R8 txe", irq_txe, x_txe);
        chk("R8 tend", irq_tend, x_tend);
        chk("R8 rxf", irq_rxf, x_rxf);
        chk("R9 stop", irq_stop, x_stop);
        chk("R10 nak", irq_nak, x_nak);
        chk("R11 any", irq_any, x_txe | x_tend | x_rxf | x_stop | x_nak);
    endtask

    // Drive one cycle of random stimulus; pct is strobe density in percent.
    task automatic drive_random(input int pct);
        logic [5:0] ev;
        bit any_set_clr;
        ev = '0;
        for (int i = 0; i < 6; i++) ev[i] = ($urandom % 100) < pct;
        {ev_arblost, ev_nack, ev_stop, ev_rxbyte, ev_txend, ev_xfer} = ev;
        txdata_wr  = ($urandom % 100) < pct;
        rxdata_rd  = ($urandom % 100) < pct;
        stat_wr    = ($urandom % 100) < pct;
        stat_wdata = 6'($urandom);
        en_wr      = ($urandom % 100) < (pct / 2);
        en_wdata   = 5'($urandom);
        any_set_clr = (txdata_wr && (ev_xfer || ev_txend)) || (rxdata_rd && ev_rxbyte) ||
                      (stat_wr && |(ev[5:3] & ~stat_wdata[5:3]));
        if (any_set_clr)    flag_tag = "R6 set-wins";
        else if (stat_wr)   flag_tag = "R5 status write";
        else if (txdata_wr) flag_tag = "R3 tx write";
        else if (rxdata_rd) flag_tag = "R4 rx read";
        else                flag_tag = "R2 set/hold";
    endtask

    task automatic idle();
        {ev_arblost, ev_nack, ev_stop, ev_rxbyte, ev_txend, ev_xfer} = '0;
        txdata_wr = 0; rxdata_rd = 0; stat_wr = 0; en_wr = 0;
        flag_tag = "R2 hold";
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        flag_tag = "R1 reset";
        compare_all();
        chk("R1 reset flags", flags_o, 6'b000001);
        rst_n = 1;
        for (int blk = 0; blk < 12; blk++) begin
            mode_i2c = blk[0];
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                compare_all();
                if (blk == 6 && c == 200) begin
                    idle(); rst_n = 0;
                    @(negedge clk);
                    rst_n = 1;
                    flag_tag = "R1 reset";
                    compare_all();
                    chk("R1 reset enables", enables_o, 0);
                end
                if (c % 50 < 5) idle();
                else drive_random((blk % 3 == 0) ? 10 : 35);
            end
        end
        @(negedge clk);
        compare_all();
        idle();
        @(negedge clk);
        compare_all();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule